// File: doc/BRIEF.md
# Host Register Access Port

This block is the slave side of a byte-wide microcontroller bus that reaches an array of 16-bit registers. A host frames each transfer with an active-low select, gives its direction on a read/write line, and places an 11-bit address beside the data byte. The block turns each framed transfer into an index, a write strobe and a 16-bit write word for a register file kept outside it. It also returns read bytes from that file.

Two ways of naming a register exist. In direct mode the index comes straight from address pins: three bits name a unit and five bits name a register inside it. In indirect mode those pins are not used. The host first writes an index byte into an internal pointer during an address phase, and later data transfers use that pointer. The lowest address bit picks the byte of the 16-bit register. Writes to the upper byte are held until the lower byte arrives, so the register changes in one step. A read of the upper byte captures the lower byte at the same time, so the two halves of a read come from the same value. When the host is routed through to a second device, the data outputs are released.

Top module: `hreg_host_if`

## Requirements
- R1: While `cs_n` is high, nothing the bus carries has any effect: `rf_we` and `doe` stay low and the index pointer keeps its value.
- R2: With `addr[10]`=1 (direct mode), `rf_addr` equals `{addr[9:7], addr[6:2]}` (unit number times 32 plus register number). `addr[1]` has no meaning in this mode.
- R3: With `addr[10]`=0 and `addr[1]`=1, a write latches `din` into the index pointer. The pointer is 0 after reset. No direct-mode access changes it.
- R4: With `addr[10]`=0 and `addr[1]`=0 (indirect data phase), `rf_addr` equals the index pointer, whatever `addr[9:2]` hold.
- R5: A data write with `addr[0]`=0 only stages `din` as the upper byte and raises no strobe. A data write with `addr[0]`=1 raises `rf_we` for its first select cycle, with `rf_wdata` = {staged byte, `din`}.
- R6: A data read with `addr[0]`=0 returns `rf_rdata[15:8]` and captures `rf_rdata[7:0]`. A data read with `addr[0]`=1 returns the byte captured by the latest upper-byte read, even if the register has since changed.
- R7: An indirect address-phase read returns the index pointer.
- R8: `doe` is high exactly when `cs_n`=0, `rw`=1, and it is not the case that `host_sel`=0 with `vid_cs_n`=1. `dout` holds the read byte from the cycle after the select falls.
- R9: Each low period of `cs_n` performs exactly one access, taken on its first cycle. Holding the select low repeats nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select framing one access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | Mode, index, phase and byte select bits |
| din | input | 8 | Byte from host (data or index) |
| dout | output | 8 | Read byte to host |
| doe | output | 1 | Output enable for `dout` |
| host_sel | input | 1 | 0 = host is routed through to the second device |
| vid_cs_n | input | 1 | Select of the second device |
| rf_addr | output | 8 | Register index to the file |
| rf_we | output | 1 | One-cycle write strobe to the file |
| rf_wdata | output | 16 | Full register word to write |
| rf_rdata | input | 16 | Word read from the file at `rf_addr` |

## Verification
The register-file outputs `rf_addr`, `rf_we` and `rf_wdata` are combinational in the first select cycle. The bench therefore drives each access on a falling clock edge and samples these outputs one nanosecond later, before the rising edge that performs the access. The read byte is registered on that rising edge. It is checked at the next falling edge, while the select is still low, together with `doe`. The checks on the pointer, on staging and on capture are made through later reads at the ports, so they need no extra timing. Tests of a held select and of the output-enable rule sample each cycle in turn.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int ADDR_W    = 11;
  localparam int DIR_BIT   = 10;
  localparam int PHASE_BIT = 1;
  localparam int BYTE_BIT  = 0;
  localparam int IDX_LO    = 2;
  localparam int IDX_HI    = 9;
  localparam int IDX_W     = IDX_HI - IDX_LO + 1;

  typedef struct packed {
    logic start;       // first cycle of a select-low period
    logic rd;          // read when set
    logic direct;      // direct addressing
    logic addr_phase;  // indirect index-load phase
    logic low_byte;    // low byte of the 16-bit word
  } hreg_acc_t;
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
  import hreg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              start,
  input  logic [IDX_W-1:0]  ptr,
  output hreg_acc_t         acc,
  output logic [IDX_W-1:0]  rf_addr
);
  always_comb begin
    acc.start      = start;
    acc.rd         = rw;
    acc.direct     = addr[DIR_BIT];
    acc.addr_phase = !addr[DIR_BIT] && addr[PHASE_BIT];
    acc.low_byte   = addr[BYTE_BIT];
    rf_addr        = addr[DIR_BIT] ? addr[IDX_HI:IDX_LO] : ptr;
  end
endmodule

// File: rtl/hreg_ptr.sv
module hreg_ptr
  import hreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hreg_acc_t        acc,
  input  logic [DW-1:0]    din,
  output logic [IDX_W-1:0] ptr_q
);
  logic             ptr_en;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_en = acc.start && !acc.rd && acc.addr_phase;
    ptr_d  = din[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/hreg_bytes.sv
module hreg_bytes
  import hreg_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hreg_acc_t        acc,
  input  logic [DW-1:0]    din,
  input  logic [IDX_W-1:0] ptr,
  input  logic [RW-1:0]    rf_rdata,
  output logic [DW-1:0]    rd_q,
  output logic             rf_we,
  output logic [RW-1:0]    rf_wdata
);
  logic [DW-1:0] stage_q, shadow_q;
  logic [DW-1:0] rd_d, ptr_ext;
  logic          data_acc, wr_hi, rd_hi, rd_lo, rd_ptr, rd_en;

  always_comb begin
    ptr_ext            = '0;
    ptr_ext[IDX_W-1:0] = ptr;
    data_acc = acc.start && !acc.addr_phase;
    wr_hi    = data_acc && !acc.rd && !acc.low_byte;
    rf_we    = data_acc && !acc.rd &&  acc.low_byte;
    rd_hi    = data_acc &&  acc.rd && !acc.low_byte;
    rd_lo    = data_acc &&  acc.rd &&  acc.low_byte;
    rd_ptr   = acc.start && acc.rd && acc.addr_phase;
    rd_en    = rd_hi || rd_lo || rd_ptr;
    rf_wdata = {stage_q, din};
    if (rd_hi)      rd_d = rf_rdata[RW-1:DW];
    else if (rd_lo) rd_d = shadow_q;
    else            rd_d = ptr_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= '0;
      rd_q     <= '0;
    end else begin
      if (wr_hi) stage_q  <= din;
      if (rd_hi) shadow_q <= rf_rdata[DW-1:0];
      if (rd_en) rd_q     <= rd_d;
    end
  end
endmodule

// File: rtl/hreg_host_if.sv
module hreg_host_if
  import hreg_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              doe,
  input  logic              host_sel,
  input  logic              vid_cs_n,
  output logic [IDX_W-1:0]  rf_addr,
  output logic              rf_we,
  output logic [RW-1:0]     rf_wdata,
  input  logic [RW-1:0]     rf_rdata
);
  logic             cs_q, start, pass_thru;
  logic [IDX_W-1:0] ptr_q;
  hreg_acc_t        acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  always_comb begin
    start     = !cs_n && cs_q;
    pass_thru = !host_sel && vid_cs_n;
    doe       = !cs_n && rw && !pass_thru;
  end

  hreg_decode u_dec (
    .addr    (addr),
    .rw      (rw),
    .start   (start),
    .ptr     (ptr_q),
    .acc     (acc),
    .rf_addr (rf_addr)
  );

  hreg_ptr #(.DW(DW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .din   (din),
    .ptr_q (ptr_q)
  );

  hreg_bytes #(.DW(DW)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .din      (din),
    .ptr      (ptr_q),
    .rf_rdata (rf_rdata),
    .rd_q     (dout),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata)
  );
endmodule

// File: rtl/hreg_host_if_chk.sv
module hreg_host_if_chk
  import hreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic              doe,
  input logic              rf_we,
  input logic [IDX_W-1:0]  ptr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!rf_we && !doe));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || addr[DIR_BIT] || rw) |=> $stable(ptr));

  assert_we_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!rw && addr[BYTE_BIT] && (addr[DIR_BIT] || !addr[PHASE_BIT])));

  assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!cs_n && rw));

  assert_single_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> !rf_we);
endmodule

bind hreg_host_if hreg_host_if_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .rw    (rw),
  .addr  (addr),
  .doe   (doe),
  .rf_we (rf_we),
  .ptr   (ptr_q)
);

// File: tb/hreg_host_if_tb.sv
module hreg_host_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rw = 1'b1, host_sel = 1'b1, vid_cs_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, rf_addr;
  logic        doe, rf_we;
  logic [15:0] rf_wdata, rf_rdata;
  logic [15:0] mem [256];
  logic [15:0] em  [256];
  int checks = 0, failures = 0;

  logic        s_we, s_doe;
  logic [7:0]  s_a, s_rd;
  logic [15:0] s_wd;

  always #5 clk = ~clk;

  hreg_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr), .din(din),
    .dout(dout), .doe(doe), .host_sel(host_sel), .vid_cs_n(vid_cs_n),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One access: first select cycle sampled before its rising edge, read byte after it.
  task automatic access(input logic r, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = r; addr = a; din = d;
    #1;
    s_we = rf_we; s_a = rf_addr; s_wd = rf_wdata;
    @(negedge clk);
    s_rd = dout; s_doe = doe;
    cs_n = 1'b1;
  endtask

  function automatic logic [10:0] daddr(input logic [7:0] idx, input logic lo, input logic junk);
    return {1'b1, idx, junk, lo};
  endfunction

  function automatic logic [10:0] iaddr(input logic [7:0] junk, input logic ph, input logic lo);
    return {1'b0, junk, ph, lo};
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; em[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R3 reset pointer", rf_addr, 8'h00);
    check("R1 reset strobe", rf_we, 1'b0);
    check("R8 reset enable", doe, 1'b0);
    access(1'b1, iaddr(8'h3C, 1'b1, 1'b0), 8'h00);
    check("R7 reset pointer read", s_rd, 8'h00);

    // Direct write sweep over every index
    for (int i = 0; i < 256; i++) begin
      logic [15:0] v;
      v = (16'(i) * 16'h0101) ^ 16'h5A3C ^ 16'(i << 5);
      access(1'b0, daddr(8'(i), 1'b0, i[0]), v[15:8]);
      check("R5 high write staged", s_we, 1'b0);
      access(1'b0, daddr(8'(i), 1'b1, ~i[0]), v[7:0]);
      check("R5 low write strobe", s_we, 1'b1);
      check("R2 direct index", s_a, 32'(i));
      check("R5 write word", s_wd, v);
      em[i] = v;
    end
    // Direct read sweep
    for (int i = 0; i < 256; i++) begin
      access(1'b1, daddr(8'(i), 1'b0, i[1]), 8'h00);
      check("R6 high read", s_rd, em[i][15:8]);
      check("R8 read enable", s_doe, 1'b1);
      access(1'b1, daddr(8'(i), 1'b1, i[2]), 8'h00);
      check("R6 low read", s_rd, em[i][7:0]);
    end

    // Indirect pointer, data phase, readback
    for (int p = 0; p < 256; p += 13) begin
      logic [15:0] w;
      w = 16'(p) * 16'h0303 + 16'h0001;
      access(1'b0, iaddr(8'(p) ^ 8'hA5, 1'b1, 1'b0), 8'(p));
      check("R3 address phase no strobe", s_we, 1'b0);
      access(1'b1, iaddr(8'(p) ^ 8'h5A, 1'b1, 1'b1), 8'h00);
      check("R7 pointer read", s_rd, 32'(p));
      access(1'b0, iaddr(8'(p) + 8'd7, 1'b0, 1'b0), w[15:8]);
      access(1'b0, iaddr(8'(p) + 8'd99, 1'b0, 1'b1), w[7:0]);
      check("R4 indirect index", s_a, 32'(p));
      check("R4 indirect word", s_wd, w);
      em[p] = w;
      access(1'b1, daddr(8'(p), 1'b0, 1'b1), 8'h00);
      check("R4 direct readback high", s_rd, w[15:8]);
      access(1'b1, iaddr(8'hFF, 1'b0, 1'b1), 8'h00);
      check("R4 indirect readback low", s_rd, w[7:0]);
    end
    // Pointer is now 247; direct accesses, including bit1 set, leave it
    access(1'b1, daddr(8'd3, 1'b0, 1'b1), 8'h00);
    access(1'b0, daddr(8'd5, 1'b0, 1'b1), 8'h44);
    check("R2 bit1 ignored in direct", s_we, 1'b0);
    access(1'b0, daddr(8'd5, 1'b1, 1'b1), 8'h55);
    check("R2 bit1 ignored direct index", s_a, 8'd5);
    check("R2 bit1 ignored direct word", s_wd, 16'h4455);
    em[5] = 16'h4455;
    access(1'b1, iaddr(8'h00, 1'b1, 1'b0), 8'h00);
    check("R3 direct keeps pointer", s_rd, 8'd247);

    // Activity with select high
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; addr = iaddr(8'h12, 1'b1, 1'b0); din = 8'h77;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R1 idle strobe", rf_we, 1'b0);
      check("R1 idle enable", doe, 1'b0);
      addr = daddr(8'(k), 1'b1, 1'b0);
      @(negedge clk);
    end
    access(1'b1, iaddr(8'h00, 1'b1, 1'b0), 8'h00);
    check("R1 idle keeps pointer", s_rd, 8'd247);
    access(1'b1, daddr(8'd9, 1'b0, 1'b0), 8'h00);
    check("R1 idle wrote nothing", s_rd, em[9][15:8]);

    // Capture of the low byte across a later write
    access(1'b1, daddr(8'd7, 1'b0, 1'b0), 8'h00);
    check("R6 capture high", s_rd, em[7][15:8]);
    access(1'b0, daddr(8'd7, 1'b0, 1'b0), 8'hE1);
    access(1'b0, daddr(8'd7, 1'b1, 1'b0), 8'hE2);
    access(1'b1, daddr(8'd7, 1'b1, 1'b0), 8'h00);
    check("R6 low from capture", s_rd, em[7][7:0]);
    em[7] = 16'hE1E2;
    access(1'b1, daddr(8'd7, 1'b0, 1'b0), 8'h00);
    access(1'b1, daddr(8'd7, 1'b1, 1'b0), 8'h00);
    check("R6 fresh low", s_rd, 8'hE2);

    // Output enable rule
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = iaddr(8'h00, 1'b1, 1'b0);
    host_sel = 1'b0; vid_cs_n = 1'b1;
    #1 check("R8 pass-through released", doe, 1'b0);
    @(negedge clk); vid_cs_n = 1'b0;
    #1 check("R8 second select low", doe, 1'b1);
    @(negedge clk); host_sel = 1'b1; vid_cs_n = 1'b1;
    #1 check("R8 host selected", doe, 1'b1);
    @(negedge clk); rw = 1'b0;
    #1 check("R8 write no enable", doe, 1'b0);
    @(negedge clk); cs_n = 1'b1;

    // Held select performs one access
    access(1'b0, daddr(8'd9, 1'b0, 1'b0), 8'hC3);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = daddr(8'd9, 1'b1, 1'b0); din = 8'h11;
    #1 check("R9 first cycle strobe", rf_we, 1'b1);
    @(negedge clk); din = 8'h22;
    #1 check("R9 held no strobe", rf_we, 1'b0);
    @(negedge clk); din = 8'h33;
    #1 check("R9 held no strobe again", rf_we, 1'b0);
    @(negedge clk); cs_n = 1'b1;
    access(1'b1, daddr(8'd9, 1'b0, 1'b0), 8'h00);
    check("R9 held high", s_rd, 8'hC3);
    access(1'b1, daddr(8'd9, 1'b1, 1'b0), 8'h00);
    check("R9 held low", s_rd, 8'h11);

    summary();
  end
endmodule